// File: doc/BRIEF.md
# Token-Ring Cascaded FIFO

This block builds one deep first-in/first-out buffer out of several identical shallow slices joined in a ring. Each slice has its own small memory, a write pointer and a read pointer. The right to store the next word and the right to supply the next word are both tokens. Each token is held by exactly one slice at a time. A slice stores a word only while it holds the write token, and supplies a word only while it holds the read token. Incoming words therefore fill the slices one after another, and the read side follows them through the slices in the same order.

When a slice writes its last location, it hands the write token to its neighbour. It does this with a one-cycle pulse on its expansion output, plus a type bit that marks the pulse as a write hand-off. Reading the last location hands the read token on in the same way, with the type bit marking a read hand-off. The last slice's expansion output feeds the first slice's expansion input, so the tokens circulate. The first slice is marked by its first-load input being held low, and after reset it holds both tokens. Every slice drives its own active-low full and empty flags. A merge stage combines them: a composite flag is asserted only when every slice asserts it.

The top module has a single write port and a single read port. The user sees one buffer of `NSLICE*DEPTH` words. Read data is registered and is qualified by a valid strobe one cycle after the read is accepted. There is no retransmit, no half-full indication, and no asynchronous strobe timing.

Top module: `fifo_chain`

## Requirements
- R1: In the reset state, `empty_n` is 0, `full_n` is 1 and `rd_valid` is 0. These values hold from two clock edges after `rst_n` rises until the first write.
- R2: Words leave in the order they were written. This holds across slice boundaries and after the ring has wrapped any number of times.
- R3: A read is accepted when `rd_en` is high at a rising edge while `empty_n` is 1. At the next rising edge, `rd_valid` goes high for one cycle and `rd_data` carries the word. In every other cycle `rd_valid` is 0.
- R4: `full_n` is 0 exactly when the buffer holds `NSLICE*DEPTH` words.
- R5: A write strobe given while `full_n` is 0 is ignored. No word is stored and none is overwritten.
- R6: A read strobe given while `empty_n` is 0 is ignored. `rd_valid` stays 0 and no word is consumed.
- R7: `empty_n` is 0 exactly when the buffer holds no word.
- R8: A write and a read in the same cycle are both accepted when their own flags allow it. When the buffer is full, only the read is accepted, and the occupancy drops by one.
- R9: The slice whose first-load input is low holds both tokens after reset. At every clock, exactly one slice holds the write token and exactly one slice holds the read token.
- R10: A slice that writes its last location pulses its expansion output for one cycle with type bit 0 (write hand-off). A slice that reads its last location pulses it with type bit 1 (read hand-off). In either case the next slice in the ring, wrapping from the last slice to the first, holds that token from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | WIDTH | Word to store |
| full_n | output | 1 | Active-low composite full flag |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rd_data | output | WIDTH | Word read, qualified by rd_valid, zero otherwise |
| rd_valid | output | 1 | High for one cycle, one cycle after an accepted read |
| empty_n | output | 1 | Active-low composite empty flag |

## Verification
The bench first fills the ring to exactly `NSLICE*DEPTH` words and keeps writing while the buffer is full. A design with an off-by-one in the occupancy count, or one whose full flag ignores a slice, would either drop `full_n` a word early or overwrite the oldest word, and the drained sequence would then differ. It then reads and writes in the same cycle while full, and reads on through empty. A design that passes a token one cycle late, or lets a non-holding slice answer a strobe, would return words out of order at each slice boundary or produce a valid strobe while empty. A long stream with random strobes drives both tokens around the ring several times, which exposes any fault in the wrap from the last slice back to the first.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;

  // Meaning of the sideband bit that travels with an expansion pulse.
  typedef enum logic {
    XFER_WR = 1'b0,
    XFER_RD = 1'b1
  } xfer_kind_e;

  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/chain_ptr.sv
module chain_ptr #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW = fifo_chain_pkg::ptr_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [PW-1:0] ptr,
  output logic          at_last
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      if (ptr_q == LAST) ptr_d = '0;
      else               ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr     = ptr_q;
  assign at_last = (ptr_q == LAST);

endmodule

// File: rtl/chain_slice.sv
module chain_slice
  import fifo_chain_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             xi,
  input  xfer_kind_e       xi_kind,
  output logic             xo,
  output xfer_kind_e       xo_kind,
  output logic             full_n,
  output logic             empty_n,
  output logic [WIDTH-1:0] q,
  output logic             q_vld,
  output logic             wtok,
  output logic             rtok
);

  localparam int unsigned PW = ptr_bits(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];

  logic [PW-1:0] wptr, rptr;
  logic          w_last, r_last;
  logic          wr_fire, rd_fire;
  logic          wr_pass, rd_pass;
  logic          wtok_q, wtok_d;
  logic          rtok_q, rtok_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [WIDTH-1:0] q_q;
  logic          q_vld_q;

  chain_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (wr_fire),
    .ptr     (wptr),
    .at_last (w_last)
  );

  chain_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (rd_fire),
    .ptr     (rptr),
    .at_last (r_last)
  );

  // Strobes count only while this slice owns the matching token.
  always_comb begin
    wr_fire = wr_en && wtok_q && (cnt_q != CNT_MAX);
    rd_fire = rd_en && rtok_q && (cnt_q != '0);
    wr_pass = wr_fire && w_last;
    rd_pass = rd_fire && r_last;
  end

  always_comb begin
    xo      = wr_pass || rd_pass;
    xo_kind = rd_pass ? XFER_RD : XFER_WR;
  end

  // Token next state: an arriving token wins over a departing one, which
  // only matters for a ring of one slice that hands the token to itself.
  always_comb begin
    wtok_d = wtok_q;
    if (wr_pass) wtok_d = 1'b0;
    if (xi && (xi_kind == XFER_WR)) wtok_d = 1'b1;

    rtok_d = rtok_q;
    if (rd_pass) rtok_d = 1'b0;
    if (xi && (xi_kind == XFER_RD)) rtok_d = 1'b1;
  end

  always_comb begin
    case ({wr_fire, rd_fire})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wtok_q  <= !first_n;
      rtok_q  <= !first_n;
      cnt_q   <= '0;
      q_q     <= '0;
      q_vld_q <= 1'b0;
    end else begin
      wtok_q  <= wtok_d;
      rtok_q  <= rtok_d;
      cnt_q   <= cnt_d;
      q_vld_q <= rd_fire;
      if (rd_fire) q_q <= mem[rptr];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr] <= wr_data;
  end

  // Local flags are asserted unless this slice can serve the strobe.
  assign full_n  = wtok_q && (cnt_q != CNT_MAX);
  assign empty_n = rtok_q && (cnt_q != '0);
  assign q       = q_q;
  assign q_vld   = q_vld_q;
  assign wtok    = wtok_q;
  assign rtok    = rtok_q;

endmodule

// File: rtl/chain_flag_merge.sv
module chain_flag_merge #(
  parameter int unsigned NSLICE = 3,
  parameter int unsigned WIDTH  = 9
) (
  input  logic [NSLICE-1:0]       full_n_vec,
  input  logic [NSLICE-1:0]       empty_n_vec,
  input  logic [NSLICE*WIDTH-1:0] q_vec,
  input  logic [NSLICE-1:0]       qv_vec,
  output logic                    full_n,
  output logic                    empty_n,
  output logic [WIDTH-1:0]        rd_data,
  output logic                    rd_valid
);

  // A composite active-low flag is asserted only when all slices assert it.
  always_comb begin
    full_n   = |full_n_vec;
    empty_n  = |empty_n_vec;
    rd_valid = |qv_vec;
    rd_data  = '0;
    for (int k = 0; k < NSLICE; k++) begin
      if (qv_vec[k]) rd_data = rd_data | q_vec[k*WIDTH +: WIDTH];
    end
  end

endmodule

// File: rtl/fifo_chain.sv
module fifo_chain
  import fifo_chain_pkg::*;
#(
  parameter int unsigned NSLICE = 3,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned WIDTH  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full_n,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             empty_n
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NSLICE-1:0]       full_n_vec, empty_n_vec, qv_vec;
  logic [NSLICE-1:0]       wtok_vec, rtok_vec, xo_vec, xo_rd_vec;
  logic [NSLICE*WIDTH-1:0] q_vec;
  xfer_kind_e              xk_w [NSLICE];

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    localparam int unsigned PRV = (k + NSLICE - 1) % NSLICE;

    chain_slice #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_slice (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .first_n ((k == 0) ? 1'b0 : 1'b1),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .xi      (xo_vec[PRV]),
      .xi_kind (xk_w[PRV]),
      .xo      (xo_vec[k]),
      .xo_kind (xk_w[k]),
      .full_n  (full_n_vec[k]),
      .empty_n (empty_n_vec[k]),
      .q       (q_vec[k*WIDTH +: WIDTH]),
      .q_vld   (qv_vec[k]),
      .wtok    (wtok_vec[k]),
      .rtok    (rtok_vec[k])
    );

    assign xo_rd_vec[k] = (xk_w[k] == XFER_RD);
  end

  chain_flag_merge #(.NSLICE(NSLICE), .WIDTH(WIDTH)) u_merge (
    .full_n_vec  (full_n_vec),
    .empty_n_vec (empty_n_vec),
    .q_vec       (q_vec),
    .qv_vec      (qv_vec),
    .full_n      (full_n),
    .empty_n     (empty_n),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
  );

endmodule

// File: rtl/fifo_chain_chk.sv
module fifo_chain_chk #(
  parameter int unsigned NSLICE = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic              full_n,
  input logic              empty_n,
  input logic              rd_valid,
  input logic [NSLICE-1:0] wtok_vec,
  input logic [NSLICE-1:0] rtok_vec,
  input logic [NSLICE-1:0] xo_vec,
  input logic [NSLICE-1:0] xo_rd_vec
);

  AST_WTOK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wtok_vec) == 1); // R9

  AST_RTOK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rtok_vec) == 1); // R9

  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty_n) |=> rd_valid); // R3

  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && empty_n) |=> !rd_valid); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !rd_en) |=> !full_n); // R5

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !wr_en) |=> !empty_n); // R7

  for (genvar k = 0; k < NSLICE; k++) begin : g_hand
    localparam int unsigned NXT = (k + 1) % NSLICE;

    AST_WR_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (xo_vec[k] && !xo_rd_vec[k]) |=> wtok_vec[NXT]); // R10

    AST_RD_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (xo_vec[k] && xo_rd_vec[k]) |=> rtok_vec[NXT]); // R10
  end

endmodule

bind fifo_chain fifo_chain_chk #(.NSLICE(NSLICE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .full_n    (full_n),
  .empty_n   (empty_n),
  .rd_valid  (rd_valid),
  .wtok_vec  (wtok_vec),
  .rtok_vec  (rtok_vec),
  .xo_vec    (xo_vec),
  .xo_rd_vec (xo_rd_vec)
);

// File: tb/fifo_chain_tb.sv
module fifo_chain_tb;

  localparam int NSLICE = 3;
  localparam int DEPTH  = 4;
  localparam int WIDTH  = 9;
  localparam int CAP    = NSLICE * DEPTH;

  logic             clk;
  logic             rst_n;
  logic             wr_en;
  logic [WIDTH-1:0] wr_data;
  logic             full_n;
  logic             rd_en;
  logic [WIDTH-1:0] rd_data;
  logic             rd_valid;
  logic             empty_n;

  int checks;
  int errors;
  int model_cnt;
  int word_no;
  logic started;
  logic exp_v;
  logic [WIDTH-1:0] sb_q [$];

  fifo_chain #(.NSLICE(NSLICE), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .full_n   (full_n),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .empty_n  (empty_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: check flags against the model, then drive one cycle of strobes.
  task automatic step(input logic we, input logic re, input string req);
    logic wacc, racc;
    logic [WIDTH-1:0] d;
    @(posedge clk);
    #2;
    check({req, " R4 full_n"},  {31'd0, full_n},  {31'd0, model_cnt != CAP});
    check({req, " R7 empty_n"}, {31'd0, empty_n}, {31'd0, model_cnt != 0});
    wacc = we && (model_cnt != CAP);
    racc = re && (model_cnt != 0);
    d = WIDTH'(word_no * 37 + 5);
    if (wacc) begin
      sb_q.push_back(d);
      word_no++;
    end
    model_cnt = model_cnt + (wacc ? 1 : 0) - (racc ? 1 : 0);
    wr_en   = we;
    wr_data = d;
    rd_en   = re;
  endtask

  // Monitor: compare valid strobe and data against the scoreboard.
  always @(negedge clk) begin
    if (started) begin
      check("R3 rd_valid", {31'd0, rd_valid}, {31'd0, exp_v});
      if (rd_valid) begin
        if (sb_q.size() == 0) begin
          check("R2 unexpected word", 32'd1, 32'd0);
        end else begin
          check("R2 order", {{(32-WIDTH){1'b0}}, rd_data},
                {{(32-WIDTH){1'b0}}, sb_q.pop_front()});
        end
      end
      exp_v = rd_en && empty_n;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; model_cnt = 0; word_no = 0;
    started = 1'b0; exp_v = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check("R1 empty_n", {31'd0, empty_n}, 32'd0);
    check("R1 full_n", {31'd0, full_n}, 32'd1);
    check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    started = 1'b1;

    // R6: reads on an empty buffer are ignored
    repeat (3) step(1'b0, 1'b1, "R6 empty read");
    // R9: first word after reset must be first out; fill to capacity
    for (int i = 0; i < CAP; i++) step(1'b1, 1'b0, "R9 fill");
    // R5: writes while full are dropped
    repeat (4) step(1'b1, 1'b0, "R5 write full");
    // R8: read and write together while full, only the read counts
    step(1'b1, 1'b1, "R8 full rw");
    step(1'b0, 1'b0, "R8 after");
    // drain completely then keep reading
    for (int i = 0; i < CAP + 3; i++) step(1'b0, 1'b1, "R6 drain");
    // R8: streaming read and write around the ring several times (R10)
    step(1'b1, 1'b0, "R10 prime");
    step(1'b1, 1'b0, "R10 prime");
    for (int i = 0; i < 5 * CAP; i++) step(1'b1, 1'b1, "R8 stream");
    // R2: random strobes over many wraps
    for (int i = 0; i < 2000; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2 random");
    for (int i = 0; i < CAP + 2; i++) step(1'b0, 1'b1, "R2 final drain");
    step(1'b0, 1'b0, "R2 idle");
    step(1'b0, 1'b0, "R2 idle");
    check("R2 scoreboard empty", sb_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule